// File: doc/BRIEF.md
# I2C Pointer-Register Write Controller

This block acts as the controller on a two-wire I2C bus and performs one complete write transaction. The transaction loads a 16-bit word into a register of a target device. A single-cycle request captures a 7-bit target address, an 8-bit register pointer and a 16-bit data word. The block then generates a START condition and sends four frames in a fixed order: the address byte with a write flag, the pointer, the upper data byte and the lower data byte. A STOP condition closes the transaction.

Neither bus line is ever driven high. Each line has an output enable, and when that enable is asserted the line is pulled low; otherwise it is released to its pull-up. After each frame the block releases SDA for a ninth clock and samples it. A high level there is a NACK. On a NACK the block sets an error flag, skips any remaining frames and goes straight to STOP. Each SCL phase, high or low, lasts `DIV` system clocks. The default of 250 gives 100 kHz from a 50 MHz clock.

Top module: `i2c_ptr_writer`

## Requirements
- R1: After reset, and whenever no transaction is running, both `scl_oe` and `sda_oe` are 0, and `busy`, `done` and `nack_err` are 0 until the first request.
- R2: A transaction opens with a START. For one phase, `sda_oe` is 1 while `scl_oe` is 0. In the next phase both are 1.
- R3: The frames are sent in this order: {addr, 1'b0}, pointer, data[15:8], data[7:0]. Bits go out MSB first, and a 0 bit is sent as `sda_oe`=1. Example: address 7'h49 gives the byte 8'h92.
- R4: Outside the START and STOP conditions, `sda_oe` changes only while `scl_oe` is 1, and it changes one system clock after SCL is pulled low.
- R5: Every bus phase lasts exactly `DIV` system clocks, whether SCL is pulled low or released.
- R6: In the ninth bit slot of every frame `sda_oe` is 0, and `sda_in` is sampled at the end of the SCL-high phase. If it is high, `nack_err` is set, no further frames are sent and STOP follows at once. `nack_err` keeps its value until the next accepted request.
- R7: A transaction closes with a STOP. For one phase both lines are pulled low. Then SCL is released while SDA stays low for one phase. Then SDA is released for one phase.
- R8: `busy` is 1 from the cycle after a request is accepted until the final STOP phase ends. `done` is 1 for exactly the one cycle after that, and `busy` is 0 in that cycle.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. The waveform and the captured values do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; accepted only while idle |
| tgt_addr | input | 7 | Target address, captured on request |
| reg_ptr | input | 8 | Register pointer byte, captured on request |
| wr_data | input | 16 | Data word, captured on request |
| sda_in | input | 1 | Level seen on the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the STOP completes |
| nack_err | output | 1 | The last transaction saw a NACK |

## Verification
Every result has a fixed cycle. The first START phase and `busy` appear in the cycle after the request edge. A change of SCL occurs in the first cycle of its phase. `sda_oe` follows one cycle after the phase that requests its new value. `nack_err` rises in the first cycle of the STOP that follows the NACK slot. `done` appears in the cycle after the last STOP phase. The bench builds the whole expected phase list for each transaction from the captured values, with `DIV` cycles per phase. It applies the one-cycle SDA lag itself, and it compares every output at the falling edge of every cycle from the request to the cycle after `done`.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int ADDR_W   = 7;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int N_FRAMES = 4;
  localparam int SLOT_W   = $clog2(BYTE_W + 1);
  localparam int FIDX_W   = $clog2(N_FRAMES);

  typedef enum logic [2:0] {
    PH_IDLE, PH_STA_A, PH_STA_B, PH_BIT_L, PH_BIT_H, PH_STO_A, PH_STO_B, PH_STO_C
  } phase_e;

  // byte carried by frame idx: address+write flag, pointer, high, low
  function automatic logic [BYTE_W-1:0] frame_byte(
    input logic [FIDX_W-1:0] idx, input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] ptr, input logic [WORD_W-1:0] data);
    case (idx)
      2'd0:    return {addr, 1'b0};
      2'd1:    return ptr;
      2'd2:    return data[WORD_W-1:BYTE_W];
      default: return data[BYTE_W-1:0];
    endcase
  endfunction

  // SDA pull request for a bit slot: slot BYTE_W is the ack slot (released)
  function automatic logic sda_pull_for(input logic [BYTE_W-1:0] b,
                                        input logic [SLOT_W-1:0] slot);
    if (slot >= SLOT_W'(BYTE_W)) return 1'b0;
    return ~b[BYTE_W-1-int'(slot)];
  endfunction

  function automatic logic scl_pull_for(input phase_e ph);
    return (ph == PH_STA_B) || (ph == PH_BIT_L) || (ph == PH_STO_A);
  endfunction
endpackage

// File: rtl/i2cw_phase_timer.sv
module i2cw_phase_timer #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cw_frame_sel.sv
module i2cw_frame_sel
  import i2cw_pkg::*;
(
  input  logic [FIDX_W-1:0] frame_idx,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] ptr,
  input  logic [WORD_W-1:0] data,
  output logic              sda_pull
);
  logic [BYTE_W-1:0] cur_byte;
  assign cur_byte = frame_byte(frame_idx, addr, ptr, data);
  assign sda_pull = sda_pull_for(cur_byte, slot_idx);
endmodule

// File: rtl/i2c_ptr_writer.sv
module i2c_ptr_writer
  import i2cw_pkg::*;
#(
  parameter int DIV = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [6:0]  tgt_addr,
  input  logic [7:0]  reg_ptr,
  input  logic [15:0] wr_data,
  input  logic        sda_in,
  output logic        sda_oe,
  output logic        scl_oe,
  output logic        busy,
  output logic        done,
  output logic        nack_err
);
  localparam logic [SLOT_W-1:0] ACK_SLOT   = SLOT_W'(BYTE_W);
  localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(N_FRAMES - 1);

  phase_e            phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic [FIDX_W-1:0] frame_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] ptr_q;
  logic [WORD_W-1:0] data_q;
  logic              nack_q, done_q, sda_oe_q;

  // named internal events, used by the checker
  logic phase_tick, accept, ack_sample, in_start, in_stop, bit_pull, sda_want;

  assign accept     = start && (phase_q == PH_IDLE);
  assign ack_sample = phase_tick && (phase_q == PH_BIT_H) && (slot_q == ACK_SLOT);
  assign in_start   = (phase_q == PH_STA_A) || (phase_q == PH_STA_B);
  assign in_stop    = (phase_q == PH_STO_A) || (phase_q == PH_STO_B) || (phase_q == PH_STO_C);

  i2cw_phase_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(phase_q != PH_IDLE), .tick(phase_tick)
  );

  i2cw_frame_sel u_fsel (
    .frame_idx(frame_q), .slot_idx(slot_q), .addr(addr_q), .ptr(ptr_q),
    .data(data_q), .sda_pull(bit_pull)
  );

  always_comb begin
    unique case (phase_q)
      PH_STA_A, PH_STA_B, PH_STO_A, PH_STO_B: sda_want = 1'b1;
      PH_BIT_L, PH_BIT_H:                     sda_want = bit_pull;
      default:                                sda_want = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      slot_q   <= '0;
      frame_q  <= '0;
      addr_q   <= '0;
      ptr_q    <= '0;
      data_q   <= '0;
      nack_q   <= 1'b0;
      done_q   <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      sda_oe_q <= sda_want;
      if (accept) begin
        phase_q <= PH_STA_A;
        addr_q  <= tgt_addr;
        ptr_q   <= reg_ptr;
        data_q  <= wr_data;
        nack_q  <= 1'b0;
        slot_q  <= '0;
        frame_q <= '0;
      end else if (phase_tick) begin
        unique case (phase_q)
          PH_STA_A: phase_q <= PH_STA_B;
          PH_STA_B: phase_q <= PH_BIT_L;
          PH_BIT_L: phase_q <= PH_BIT_H;
          PH_BIT_H: begin
            if (slot_q != ACK_SLOT) begin
              slot_q  <= slot_q + 1'b1;
              phase_q <= PH_BIT_L;
            end else if (sda_in) begin
              nack_q  <= 1'b1;
              phase_q <= PH_STO_A;
            end else if (frame_q == LAST_FRAME) begin
              phase_q <= PH_STO_A;
            end else begin
              frame_q <= frame_q + 1'b1;
              slot_q  <= '0;
              phase_q <= PH_BIT_L;
            end
          end
          PH_STO_A: phase_q <= PH_STO_B;
          PH_STO_B: phase_q <= PH_STO_C;
          PH_STO_C: begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
          default:  phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign sda_oe   = sda_oe_q;
  assign scl_oe   = scl_pull_for(phase_q);
  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign nack_err = nack_q;
endmodule

// File: rtl/i2c_ptr_writer_chk.sv
module i2c_ptr_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sda_in,
  input logic sda_oe,
  input logic scl_oe,
  input logic busy,
  input logic done,
  input logic nack_err,
  input logic ack_sample,
  input logic in_start,
  input logic in_stop
);
  // R1: released lines whenever idle
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
  // R4 / R2: SDA pulled while SCL is released only inside a START
  a_r4_sda_fall_in_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe) |-> in_start);
  // R4 / R7: SDA released while SCL is released only inside a STOP
  a_r4_sda_rise_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe) |-> (in_stop || !busy));
  // R6: a high ack sample leads straight to STOP with the flag set
  a_r6_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_sample && sda_in) |=> (in_stop && scl_oe && nack_err));
  // R8: done is a single cycle and never overlaps busy
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: a request during a transaction does not restart it
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !in_start) |=> !in_start);
endmodule

bind i2c_ptr_writer i2c_ptr_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sda_in(sda_in), .sda_oe(sda_oe),
  .scl_oe(scl_oe), .busy(busy), .done(done), .nack_err(nack_err),
  .ack_sample(ack_sample), .in_start(in_start), .in_stop(in_stop)
);

// File: tb/i2c_ptr_writer_tb.sv
module i2c_ptr_writer_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] tgt_addr = '0;
  logic [7:0] reg_ptr = '0;
  logic [15:0] wr_data = '0;
  logic tgt_pull = 1'b0;
  logic sda_in, sda_oe, scl_oe, busy, done, nack_err;

  always #5 clk = ~clk;

  assign sda_in = !(sda_oe || tgt_pull);

  i2c_ptr_writer #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr),
    .reg_ptr(reg_ptr), .wr_data(wr_data), .sda_in(sda_in), .sda_oe(sda_oe),
    .scl_oe(scl_oe), .busy(busy), .done(done), .nack_err(nack_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: one entry per system clock
  bit q_scl[$];
  bit q_sda[$];
  bit q_pull[$];
  bit q_nk[$];
  int q_kind[$];  // 0 start, 1 data, 2 ack, 3 stop

  function automatic void push_phase(bit scl, bit sda, bit pull, bit nk, int kind);
    for (int k = 0; k < DIV; k++) begin
      q_scl.push_back(scl); q_sda.push_back(sda); q_pull.push_back(pull);
      q_nk.push_back(nk);   q_kind.push_back(kind);
    end
  endfunction

  function automatic string kind_tag(int kind);
    case (kind)
      0: return "R2";
      1: return "R3";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // nack_frame: -1 means every frame is acknowledged
  task automatic run_txn(input logic [6:0] a, input logic [7:0] p,
                         input logic [15:0] d, input int nack_frame,
                         input bit poke_start);
    logic [7:0] bytes [4];
    bit nk = 0;
    bit prev_want = 0;
    bit prev_sda;
    int n;
    q_scl.delete(); q_sda.delete(); q_pull.delete(); q_nk.delete(); q_kind.delete();
    bytes[0] = {a, 1'b0}; bytes[1] = p; bytes[2] = d[15:8]; bytes[3] = d[7:0];
    push_phase(0, 1, 0, 0, 0);
    push_phase(1, 1, 0, 0, 0);
    for (int f = 0; f < 4 && !nk; f++) begin
      for (int b = 7; b >= 0; b--) begin
        push_phase(1, !bytes[f][b], 0, 0, 1);
        push_phase(0, !bytes[f][b], 0, 0, 1);
      end
      push_phase(1, 0, f != nack_frame, 0, 2);
      push_phase(0, 0, f != nack_frame, 0, 2);
      if (f == nack_frame) nk = 1;
    end
    push_phase(1, 1, 0, nk, 3);
    push_phase(0, 1, 0, nk, 3);
    push_phase(0, 0, 0, nk, 3);
    n = q_scl.size();

    @(negedge clk);
    tgt_addr = a; reg_ptr = p; wr_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev_sda = sda_oe;
    for (int i = 0; i < n; i++) begin
      tgt_pull = q_pull[i];
      if (poke_start && i == n / 2) begin
        start = 1'b1; tgt_addr = ~a; reg_ptr = ~p; wr_data = ~d;
      end else begin
        start = 1'b0;
      end
      chk(scl_oe == q_scl[i], "R5", "scl_oe", scl_oe, q_scl[i]);
      chk(sda_oe == prev_want, poke_start ? "R9" : kind_tag(q_kind[i]),
          "sda_oe", sda_oe, prev_want);
      if (i > 0 && sda_oe != prev_sda && !scl_oe)
        chk(q_kind[i] == 0 || q_kind[i] == 3, "R4", "sda edge while scl high kind",
            q_kind[i], 0);
      chk(busy == 1'b1, "R8", "busy", busy, 1);
      chk(done == 1'b0, "R8", "done early", done, 0);
      chk(nack_err == q_nk[i], "R6", "nack_err", nack_err, q_nk[i]);
      prev_want = q_sda[i];
      prev_sda = sda_oe;
      @(negedge clk);
    end
    tgt_pull = 1'b0;
    start = 1'b0;
    chk(busy == 1'b0, "R8", "busy after stop", busy, 0);
    chk(done == 1'b1, "R8", "done pulse", done, 1);
    chk(nack_err == nk, "R6", "nack_err held", nack_err, nk);
    chk(!sda_oe && !scl_oe, "R7", "lines released", {sda_oe, scl_oe}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", done, 0);
    chk(nack_err == nk, "R6", "nack_err kept", nack_err, nk);
    chk(!sda_oe && !scl_oe, "R1", "idle lines", {sda_oe, scl_oe}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!sda_oe && !scl_oe && !busy && !done && !nack_err, "R1", "reset outputs",
        {sda_oe, scl_oe, busy, done, nack_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!sda_oe && !scl_oe && !busy && !done && !nack_err, "R1", "idle after reset",
        {sda_oe, scl_oe, busy, done, nack_err}, 0);
    // R3: example frame set 0x92, 0x08, 0x4C, 0xCD
    run_txn(7'h49, 8'h08, 16'h4CCD, -1, 0);
    run_txn(7'h7F, 8'hFF, 16'hFFFF, -1, 0);
    run_txn(7'h00, 8'h00, 16'h0000, -1, 0);
    run_txn(7'h2A, 8'h5A, 16'hA55A, -1, 0);
    // R6: NACK on address, on high data byte and on last byte
    run_txn(7'h13, 8'h21, 16'h1234, 0, 0);
    run_txn(7'h49, 8'h08, 16'h4CCD, 2, 0);
    run_txn(7'h31, 8'hC3, 16'h8001, 3, 0);
    // R6: flag cleared by the next accepted request
    run_txn(7'h49, 8'h08, 16'h4CCD, -1, 0);
    // R9: request in mid transaction is ignored
    run_txn(7'h55, 8'h3C, 16'hF00F, -1, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule